// File: doc/BRIEF.md
# Local-Bus to Backplane Wait-State Bridge

This block sits between a fast 32-bit CPU local bus and a slower parallel backplane. Each time the CPU marks the start of a bus cycle, the block decodes the memory/IO, data/control and write/read status lines, together with the address. It then decides whether the cycle must run at backplane speed. Slow cycles are I/O reads and writes, interrupt acknowledge, and memory accesses below 1 MB. For these, the block holds the CPU ready line low for a programmed number of waits. It also presents the captured address, byte enables and status to the backplane, and issues a sync strobe followed by a status-valid strobe, both aligned to a divided backplane clock. All other cycles are acknowledged at once and leave the backplane untouched.

The CPU keeps its clock. Only the backplane receives the divided copy. The CPU holds its outputs stable while ready is low, so the captured status stays valid for the whole stretched cycle. The CPU start strobe lasts only one cycle, so the backplane strobes are produced here and not passed through.

Top module: `slowbus_wait_bridge`

## Requirements
- R1: A start is slow when its status code {cpu_mio,cpu_dc,cpu_wr} is 000 (interrupt acknowledge), 010 or 011 (I/O read or write), or 100, 110 or 111 (memory) with cpu_addr below 0x0010_0000.
- R2: Every other start is fast. This covers codes 001 and 101, and memory codes 100, 110 and 111 at or above 0x0010_0000. For a fast start, cpu_ready is high in the cycle that follows the edge where the start was sampled, and bp_active, bp_sync and bp_stval stay low.
- R3: Number the clock edges from the first edge with rst_n high, which is edge 1. For a slow start sampled at edge E0, W = min(wait_cfg, 16) is taken at E0. Es is the first multiple of DIV greater than E0. cpu_ready is high in the cycle after edge max(E0+W, Es+2*DIV)+1. Ready therefore never comes before both the wait count and the strobe sequence are finished.
- R4: cpu_ready is high for exactly one cycle per accepted start.
- R5: After edge n, bp_clk equals 1 when (n mod DIV) is at least DIV/2, and 0 otherwise. DIV is 2**DIV_LOG2.
- R6: For a slow start, bp_sync is high in the cycles after edges Es through Es+DIV-1, and bp_stval is high after edges Es+DIV through Es+2*DIV-1. Each strobe lasts exactly one backplane clock period, and the two never overlap.
- R7: bp_active is high from the cycle after E0 through the ready cycle of a slow start. During that window bp_addr, bp_be, bp_mio, bp_dc and bp_wr equal the inputs sampled at E0. Neither strobe is high while bp_active is low.
- R8: A start that arrives while a slow cycle is waiting, or during any ready cycle, is ignored. Ready timing, strobes and the presented status are unchanged.
- R9: While rst_n is low at a clock edge, the outputs after that edge are as follows: cpu_ready, bp_sync, bp_stval, bp_active and bp_clk are 0, the divider phase restarts, and the presented status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_start | input | 1 | CPU cycle-start strobe, high for one cycle |
| cpu_mio | input | 1 | 1 = memory, 0 = I/O space |
| cpu_dc | input | 1 | 1 = data, 0 = control or code |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_be | input | BE_W | CPU byte enables |
| wait_cfg | input | CFG_W | Programmed wait count, values above 16 act as 16 |
| cpu_ready | output | 1 | Ready to the CPU, one-cycle pulse ending a cycle |
| bp_clk | output | 1 | Divided backplane clock |
| bp_sync | output | 1 | Backplane sync strobe |
| bp_stval | output | 1 | Backplane status-valid strobe |
| bp_active | output | 1 | Backplane cycle in progress |
| bp_addr | output | ADDR_W | Address presented to the backplane |
| bp_be | output | BE_W | Byte enables presented to the backplane |
| bp_mio | output | 1 | Presented memory/IO status |
| bp_dc | output | 1 | Presented data/control status |
| bp_wr | output | 1 | Presented write/read status |

## Verification
A wrong sequencer state shows up on cpu_ready at once. Ready can come a cycle early or late, it can be missing, or it can last two cycles. The bench checks this edge by edge against the numbering in R3. A strobe phase that slips shows up within one backplane period as a strobe starting off a divider boundary or having the wrong width. A corrupted capture register shows up on the presented status in the very next cycle of the slow window. Random starts issued while the block is busy expose any path that lets a second start overwrite the first.

// File: rtl/sbw_pkg.sv
// Shared types for the backplane wait-state bridge.
// Assumes the status code is ordered {memory/IO, data/control, write/read}.
package sbw_pkg;

    // Cycle class, encoded directly as the {mio, dc, wr} status code.
    typedef enum logic [2:0] {
        CK_INTA   = 3'b000,
        CK_RSVD   = 3'b001,
        CK_IO_RD  = 3'b010,
        CK_IO_WR  = 3'b011,
        CK_CODE   = 3'b100,
        CK_HALT   = 3'b101,
        CK_MEM_RD = 3'b110,
        CK_MEM_WR = 3'b111
    } cyc_kind_e;

    // Sequencer states for one CPU cycle.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_READY = 2'd2
    } seq_state_e;

    // Backplane strobe phases.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ARMED = 3'd1,
        PH_SYNC  = 3'd2,
        PH_STVAL = 3'd3,
        PH_DONE  = 3'd4
    } strobe_ph_e;

    // Captured CPU status lines.
    typedef struct packed {
        logic mio;
        logic dc;
        logic wr;
    } cyc_status_t;

endpackage

// File: rtl/sbw_clkdiv.sv
// Backplane clock divider.
// A free-running phase counter divides clk by 2**DIV_LOG2. bp_clk is the
// counter MSB, so it is low for the first half of each period. period_end
// flags the last cycle of a period, so the edge that follows starts a new one.
// Assumes DIV_LOG2 >= 1. Synchronous reset restarts the phase at zero.
module sbw_clkdiv #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_clk,
    output logic period_end
);

    logic [DIV_LOG2-1:0] phase_q;

    // Advance the divider phase once per CPU clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign bp_clk     = phase_q[DIV_LOG2-1];
    assign period_end = &phase_q;

endmodule

// File: rtl/sbw_decode.sv
// Cycle classifier.
// Maps the status code and address of a starting cycle to slow or fast.
// I/O and interrupt acknowledge are always slow. Memory is slow below
// 2**LOW_LIMIT_LOG2. Reserved and halt-type codes are fast.
// Assumes the inputs are valid whenever the start strobe is sampled.
module sbw_decode
    import sbw_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int LOW_LIMIT_LOG2 = 20
) (
    input  cyc_status_t       status,
    input  logic [ADDR_W-1:0] addr,
    output logic              slow
);

    cyc_kind_e kind;
    logic      addr_low;

    assign kind = cyc_kind_e'({status.mio, status.dc, status.wr});

    generate
        if (LOW_LIMIT_LOG2 >= ADDR_W) begin : g_all_low
            // The whole address space lies below the limit.
            assign addr_low = 1'b1;
        end else begin : g_cmp_low
            localparam logic [ADDR_W:0] LIMIT_VAL = (ADDR_W + 1)'(1) << LOW_LIMIT_LOG2;
            // Compare the address against the slow-memory ceiling.
            assign addr_low = ({1'b0, addr} < LIMIT_VAL);
        end
    endgenerate

    // Select slow or fast according to the cycle class.
    always_comb begin
        case (kind)
            CK_INTA, CK_IO_RD, CK_IO_WR:    slow = 1'b1;
            CK_CODE, CK_MEM_RD, CK_MEM_WR:  slow = addr_low;
            default:                        slow = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbw_strobe.sv
// Backplane strobe sequencer.
// Once armed, it waits for the next divider boundary. It then holds sync for
// one backplane period, then status-valid for one period, and reports done.
// It stays done until the cycle is released.
// Assumes arm arrives only while idle. clear has priority over every phase.
module sbw_strobe
    import sbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    input  logic period_end,
    output logic sync,
    output logic stval,
    output logic done
);

    strobe_ph_e ph_q;
    strobe_ph_e ph_d;

    // Choose the next strobe phase.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (arm)        ph_d = PH_ARMED;
            PH_ARMED: if (period_end) ph_d = PH_SYNC;
            PH_SYNC:  if (period_end) ph_d = PH_STVAL;
            PH_STVAL: if (period_end) ph_d = PH_DONE;
            default:                  ph_d = ph_q;
        endcase
        if (clear) begin
            ph_d = PH_IDLE;
        end
    end

    // Hold the current strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign sync  = (ph_q == PH_SYNC);
    assign stval = (ph_q == PH_STVAL);
    assign done  = (ph_q == PH_DONE);

endmodule

// File: rtl/sbw_seq.sv
// Cycle sequencer with wait counter and status capture.
// A start is accepted only in idle. A fast start goes straight to the
// one-cycle ready state. A slow start loads the clamped wait count, arms the
// strobe sequencer and captures address, byte enables and status. It leaves
// the wait state only when the count is zero and the strobes are done.
// Assumes wait_cfg is stable in the cycle the start is sampled.
module sbw_seq
    import sbw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BE_W     = 4,
    parameter int WAIT_MAX = 16,
    parameter int CFG_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              slow,
    input  logic [CFG_W-1:0]  wait_cfg,
    input  logic              strobe_done,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  cyc_status_t       status,
    output logic              ready,
    output logic              active,
    output logic              arm,
    output logic              strobe_clear,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BE_W-1:0]   lat_be,
    output cyc_status_t       lat_status
);

    localparam logic [CFG_W-1:0] WAIT_CAP = CFG_W'(WAIT_MAX);

    seq_state_e       state_q;
    logic [CFG_W-1:0] wcnt_q;
    logic [CFG_W-1:0] wait_eff;
    logic             slow_q;
    logic             accept;

    assign wait_eff     = (wait_cfg > WAIT_CAP) ? WAIT_CAP : wait_cfg;
    assign accept       = (state_q == SEQ_IDLE) && start;
    assign arm          = accept && slow;
    assign ready        = (state_q == SEQ_READY);
    assign strobe_clear = (state_q == SEQ_READY);
    assign active       = slow_q && (state_q != SEQ_IDLE);

    // Step the cycle state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= slow ? SEQ_WAIT : SEQ_READY;
                    end
                end
                SEQ_WAIT: begin
                    if ((wcnt_q == '0) && strobe_done) begin
                        state_q <= SEQ_READY;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Load the wait count on a slow start and count it down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (arm) begin
            wcnt_q <= wait_eff;
        end else if ((state_q == SEQ_WAIT) && (wcnt_q != '0)) begin
            wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // Remember whether the accepted cycle uses the backplane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q <= 1'b0;
        end else if (accept) begin
            slow_q <= slow;
        end
    end

    // Capture the CPU address and status for the backplane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr   <= '0;
            lat_be     <= '0;
            lat_status <= '0;
        end else if (arm) begin
            lat_addr   <= addr;
            lat_be     <= be;
            lat_status <= status;
        end
    end

endmodule

// File: rtl/slowbus_wait_bridge.sv
// Top level of the CPU local-bus to backplane wait-state bridge.
// It ties together the classifier, the sequencer, the strobe generator and
// the clock divider. All outputs come from registers. The CPU is expected
// to hold its status lines stable while ready is low.
module slowbus_wait_bridge
    import sbw_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int BE_W           = 4,
    parameter int WAIT_MAX       = 16,
    parameter int DIV_LOG2       = 2,
    parameter int LOW_LIMIT_LOG2 = 20,
    localparam int CFG_W         = $clog2(WAIT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_start,
    input  logic              cpu_mio,
    input  logic              cpu_dc,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [CFG_W-1:0]  wait_cfg,
    output logic              cpu_ready,
    output logic              bp_clk,
    output logic              bp_sync,
    output logic              bp_stval,
    output logic              bp_active,
    output logic [ADDR_W-1:0] bp_addr,
    output logic [BE_W-1:0]   bp_be,
    output logic              bp_mio,
    output logic              bp_dc,
    output logic              bp_wr
);

    cyc_status_t cur_status;
    cyc_status_t lat_status;
    logic        is_slow;
    logic        period_end;
    logic        arm;
    logic        strobe_clear;
    logic        strobe_done;

    assign cur_status = '{mio: cpu_mio, dc: cpu_dc, wr: cpu_wr};

    sbw_decode #(
        .ADDR_W        (ADDR_W),
        .LOW_LIMIT_LOG2(LOW_LIMIT_LOG2)
    ) u_decode (
        .status(cur_status),
        .addr  (cpu_addr),
        .slow  (is_slow)
    );

    sbw_clkdiv #(
        .DIV_LOG2(DIV_LOG2)
    ) u_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_clk    (bp_clk),
        .period_end(period_end)
    );

    sbw_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .clear     (strobe_clear),
        .period_end(period_end),
        .sync      (bp_sync),
        .stval     (bp_stval),
        .done      (strobe_done)
    );

    sbw_seq #(
        .ADDR_W  (ADDR_W),
        .BE_W    (BE_W),
        .WAIT_MAX(WAIT_MAX),
        .CFG_W   (CFG_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cpu_start),
        .slow        (is_slow),
        .wait_cfg    (wait_cfg),
        .strobe_done (strobe_done),
        .addr        (cpu_addr),
        .be          (cpu_be),
        .status      (cur_status),
        .ready       (cpu_ready),
        .active      (bp_active),
        .arm         (arm),
        .strobe_clear(strobe_clear),
        .lat_addr    (bp_addr),
        .lat_be      (bp_be),
        .lat_status  (lat_status)
    );

    assign bp_mio = lat_status.mio;
    assign bp_dc  = lat_status.dc;
    assign bp_wr  = lat_status.wr;

endmodule

// File: rtl/sbw_checker.sv
// Protocol checker for the wait-state bridge, bound to the top level.
// It watches only the top-level ports. Pulse widths are measured with local
// run counters instead of deep $past chains.
module sbw_checker #(
    parameter int DIV_LOG2 = 2,
    parameter int ADDR_W   = 32,
    parameter int BE_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              bp_clk,
    input logic              bp_sync,
    input logic              bp_stval,
    input logic              bp_active,
    input logic [ADDR_W-1:0] bp_addr,
    input logic [BE_W-1:0]   bp_be,
    input logic              bp_mio,
    input logic              bp_dc,
    input logic              bp_wr
);

    localparam int RUN_W = DIV_LOG2 + 2;
    localparam logic [RUN_W-1:0] FULL = RUN_W'(2 ** DIV_LOG2);
    localparam logic [RUN_W-1:0] HALF = RUN_W'(2 ** (DIV_LOG2 - 1));

    logic [RUN_W-1:0] sync_run;
    logic [RUN_W-1:0] stval_run;
    logic [RUN_W-1:0] clk_run;
    logic             clk_prev;

    // Measure how long each strobe has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_run  <= '0;
            stval_run <= '0;
        end else begin
            sync_run  <= bp_sync  ? sync_run + 1'b1  : '0;
            stval_run <= bp_stval ? stval_run + 1'b1 : '0;
        end
    end

    // Measure how long the backplane clock has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            clk_run  <= '0;
        end else begin
            clk_prev <= bp_clk;
            clk_run  <= (bp_clk == clk_prev) ? clk_run + 1'b1 : RUN_W'(1);
        end
    end

    // R4: ready is a single-cycle pulse
    p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R3: a slow cycle completes only after both strobes have ended
    p_ready_after_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && bp_active) |-> (!bp_sync && !bp_stval));

    // R5: each backplane clock level lasts half a divided period
    p_clk_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp_clk) && $past(rst_n)) |-> (clk_run == HALF));

    // R6: the two strobes never overlap
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_sync && bp_stval));

    // R6: sync lasts one full divided period
    p_sync_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_sync) |-> (sync_run == FULL));

    // R6: status-valid lasts one full divided period
    p_stval_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_stval) |-> (stval_run == FULL));

    // R6: status-valid follows sync directly
    p_sync_to_stval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_sync) |-> bp_stval);

    // R7: strobes only inside a backplane cycle
    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_active |-> (!bp_sync && !bp_stval));

    // R7, R8: presented status holds for the whole backplane cycle
    p_status_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_active && $past(bp_active)) |->
            $stable({bp_addr, bp_be, bp_mio, bp_dc, bp_wr}));

    // R9: reset clears the handshake and backplane outputs
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!cpu_ready && !bp_sync && !bp_stval && !bp_active && !bp_clk));

endmodule

bind slowbus_wait_bridge sbw_checker #(
    .DIV_LOG2(DIV_LOG2),
    .ADDR_W  (ADDR_W),
    .BE_W    (BE_W)
) u_sbw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ready(cpu_ready),
    .bp_clk   (bp_clk),
    .bp_sync  (bp_sync),
    .bp_stval (bp_stval),
    .bp_active(bp_active),
    .bp_addr  (bp_addr),
    .bp_be    (bp_be),
    .bp_mio   (bp_mio),
    .bp_dc    (bp_dc),
    .bp_wr    (bp_wr)
);

// File: tb/slowbus_wait_bridge_tb_top.sv
// Self-checking bench for the wait-state bridge.
// Directed corner cases and seeded random cycles are compared, edge by edge,
// with timing worked out from the requirements.
module slowbus_wait_bridge_tb_top;

    localparam int ADDR_W   = 32;
    localparam int BE_W     = 4;
    localparam int WAIT_MAX = 16;
    localparam int DIV_LOG2 = 2;
    localparam int DIV      = 2 ** DIV_LOG2;
    localparam int CFG_W    = $clog2(WAIT_MAX + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_start = 1'b0;
    logic              cpu_mio = 1'b0;
    logic              cpu_dc = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [BE_W-1:0]   cpu_be = '0;
    logic [CFG_W-1:0]  wait_cfg = '0;
    logic              cpu_ready;
    logic              bp_clk;
    logic              bp_sync;
    logic              bp_stval;
    logic              bp_active;
    logic [ADDR_W-1:0] bp_addr;
    logic [BE_W-1:0]   bp_be;
    logic              bp_mio;
    logic              bp_dc;
    logic              bp_wr;

    int n = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    slowbus_wait_bridge #(
        .ADDR_W  (ADDR_W),
        .BE_W    (BE_W),
        .WAIT_MAX(WAIT_MAX),
        .DIV_LOG2(DIV_LOG2)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_start(cpu_start),
        .cpu_mio  (cpu_mio),
        .cpu_dc   (cpu_dc),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_be   (cpu_be),
        .wait_cfg (wait_cfg),
        .cpu_ready(cpu_ready),
        .bp_clk   (bp_clk),
        .bp_sync  (bp_sync),
        .bp_stval (bp_stval),
        .bp_active(bp_active),
        .bp_addr  (bp_addr),
        .bp_be    (bp_be),
        .bp_mio   (bp_mio),
        .bp_dc    (bp_dc),
        .bp_wr    (bp_wr)
    );

    always #5 clk = ~clk;

    // Edge numbering as used by the requirements: edge 1 is the first edge out of reset.
    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, n, act, exp);
        end
    endtask

    function automatic bit model_slow(bit mio, bit dc, bit wr, logic [ADDR_W-1:0] addr);
        if (!mio) return !(!dc && wr);
        if (!dc && wr) return 1'b0;
        return addr < 32'h0010_0000;
    endfunction

    function automatic int model_ready_edge(int e0, int w, bit slow);
        int es;
        int ed;
        if (!slow) return e0;
        es = (e0 / DIV + 1) * DIV;
        ed = es + 2 * DIV;
        return ((e0 + w) > ed ? (e0 + w) : ed) + 1;
    endfunction

    // Issue one cycle start and check every output edge by edge until it ends.
    task automatic run_cycle(bit mio, bit dc, bit wr, logic [ADDR_W-1:0] addr,
                             logic [BE_W-1:0] be, logic [CFG_W-1:0] cfg, bit noise);
        int  e0;
        int  er;
        int  es;
        int  w;
        int  pulses;
        bit  slow;
        string rq;
        @(negedge clk);
        cpu_start = 1'b1;
        cpu_mio   = mio;
        cpu_dc    = dc;
        cpu_wr    = wr;
        cpu_addr  = addr;
        cpu_be    = be;
        wait_cfg  = cfg;
        e0     = n + 1;
        slow   = model_slow(mio, dc, wr, addr);
        w      = (int'(cfg) > WAIT_MAX) ? WAIT_MAX : int'(cfg);
        er     = model_ready_edge(e0, w, slow);
        es     = (e0 / DIV + 1) * DIV;
        pulses = 0;
        rq     = noise ? "R8" : (slow ? "R1 R3" : "R2");
        do begin
            @(negedge clk);
            cpu_start = 1'b0;
            if (cpu_ready) pulses++;
            check_eq(rq, "cpu_ready", cpu_ready, (n == er));
            check_eq("R5", "bp_clk", bp_clk, ((n % DIV) >= DIV / 2));
            check_eq(slow ? "R6" : "R2", "bp_sync", bp_sync, slow && n >= es && n < es + DIV);
            check_eq(slow ? "R6" : "R2", "bp_stval", bp_stval,
                     slow && n >= es + DIV && n < es + 2 * DIV);
            check_eq(slow ? "R7" : "R2", "bp_active", bp_active, slow && n >= e0 && n <= er);
            if (slow && n <= er) begin
                check_eq(noise ? "R8" : "R7", "bp_addr", bp_addr, addr);
                check_eq(noise ? "R8" : "R7", "bp_be", bp_be, be);
                check_eq(noise ? "R8" : "R7", "bp_status", {bp_mio, bp_dc, bp_wr}, {mio, dc, wr});
            end
            if (noise && n <= er && ($urandom % 2) == 1) begin
                cpu_start = 1'b1;
                cpu_mio   = 1'($urandom);
                cpu_dc    = 1'($urandom);
                cpu_wr    = 1'($urandom);
                cpu_addr  = $urandom % 32'h0002_0000;
                cpu_be    = 4'($urandom);
                wait_cfg  = CFG_W'($urandom);
            end
        end while (n <= er && n < e0 + 200);
        cpu_start = 1'b0;
        check_eq("R4", "ready pulse count", pulses, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        repeat (3) @(negedge clk);
        // R9: outputs after reset
        check_eq("R9", "reset cpu_ready", cpu_ready, 0);
        check_eq("R9", "reset bp_sync", bp_sync, 0);
        check_eq("R9", "reset bp_stval", bp_stval, 0);
        check_eq("R9", "reset bp_active", bp_active, 0);
        check_eq("R9", "reset bp_clk", bp_clk, 0);
        check_eq("R9", "reset bp_addr", bp_addr, 0);
        rst_n = 1'b1;

        // Directed corner cases.
        run_cycle(1'b0, 1'b1, 1'b0, 32'h0000_0080, 4'h1, 5'd0,  1'b0); // R1 I/O read, no waits
        run_cycle(1'b0, 1'b1, 1'b1, 32'h0000_03F8, 4'h2, 5'd16, 1'b0); // R3 maximum waits
        run_cycle(1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'hF, 5'd5,  1'b0); // R1 interrupt acknowledge
        run_cycle(1'b1, 1'b1, 1'b0, 32'h000F_FFFC, 4'hC, 5'd3,  1'b0); // R1 just below limit
        run_cycle(1'b1, 1'b1, 1'b1, 32'h0010_0000, 4'h3, 5'd9,  1'b0); // R2 at the limit
        run_cycle(1'b1, 1'b0, 1'b0, 32'h8000_0000, 4'hF, 5'd9,  1'b0); // R2 high code fetch
        run_cycle(1'b0, 1'b0, 1'b1, 32'h0000_0010, 4'h1, 5'd9,  1'b0); // R2 reserved code
        run_cycle(1'b1, 1'b0, 1'b1, 32'h0000_0002, 4'h4, 5'd9,  1'b0); // R2 halt code
        run_cycle(1'b0, 1'b1, 1'b0, 32'h0000_0040, 4'h8, 5'd31, 1'b0); // R3 clamp to 16
        run_cycle(1'b1, 1'b1, 1'b1, 32'h0001_2340, 4'h6, 5'd14, 1'b1); // R8 starts while busy
        run_cycle(1'b1, 1'b1, 1'b0, 32'h7000_0000, 4'hF, 5'd0,  1'b1); // R8 start during fast ready

        // Seeded random cycles.
        for (int i = 0; i < 150; i++) begin
            logic [ADDR_W-1:0] a;
            a = (($urandom % 2) == 1) ? ($urandom % 32'h0010_0000) : $urandom;
            run_cycle(1'($urandom), 1'($urandom), 1'($urandom), a, 4'($urandom),
                      CFG_W'($urandom), (($urandom % 4) == 0));
        end

        // R9: reset in the middle of a slow cycle.
        @(negedge clk);
        cpu_start = 1'b1;
        cpu_mio   = 1'b0;
        cpu_dc    = 1'b1;
        cpu_wr    = 1'b0;
        cpu_addr  = 32'h0000_1234;
        wait_cfg  = 5'd10;
        @(negedge clk);
        cpu_start = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R7", "mid-cycle bp_active", bp_active, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R9", "mid reset cpu_ready", cpu_ready, 0);
        check_eq("R9", "mid reset bp_sync", bp_sync, 0);
        check_eq("R9", "mid reset bp_stval", bp_stval, 0);
        check_eq("R9", "mid reset bp_active", bp_active, 0);
        check_eq("R9", "mid reset bp_clk", bp_clk, 0);
        check_eq("R9", "mid reset bp_addr", bp_addr, 0);
        rst_n = 1'b1;
        // Divider phase must restart: checked edge by edge inside the next cycle.
        run_cycle(1'b0, 1'b1, 1'b1, 32'h0000_0300, 4'h1, 5'd2, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule